// File: doc/BRIEF.md
# ADC Conversion Sequence Channel Controller

This block is the digital sequencer that sits in front of an eight-input analog multiplexer and a successive-approximation converter. A one-cycle start pulse latches four settings: a 4-bit select code, a multi-channel mode bit, a 4-bit wrap setting and a 4-bit sequence length. The block then steps through the sequence one conversion at a time. For each slot it holds a convert request with a stable channel number and waits for the converter's done strobe. When the strobe arrives it reports the converted channel together with its slot index.

In single-channel mode every slot converts the same input. In multi-channel mode the first slot uses the selected input and each later slot uses the next higher one. The count returns to input 0 after the input equal to the wrap setting has been converted. If the sequence starts above the wrap point, the first return to input 0 happens only after input 7. A one-cycle completion pulse marks the last result. A new start pulse at any time abandons the running sequence and begins again from slot 0 with the new settings.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and directly after synchronous reset, conv_req_o, res_valid_o and seq_done_o are 0.
- R2: Select codes 0 to 7 address inputs 0 to 7. Every code from 8 to 15 addresses input 7, in both modes.
- R3: With multi_i = 0 at start, every slot of the sequence converts the input given by the select code.
- R4: With multi_i = 1, the first slot converts the selected input. Each later slot converts the previous input plus one, except that after the input equal to the effective wrap setting it converts input 0. A wrap setting of 0 or of 8 to 15 acts as 7.
- R5: In multi-channel mode, when the starting input is above the effective wrap setting, the first return to input 0 follows input 7. Every later return follows the wrap setting.
- R6: The sequence has len_i conversions for len_i = 1 to 8. A len_i of 0 or of 9 to 15 gives 8 conversions.
- R7: conv_req_o rises in the cycle after a start pulse. chan_o holds steady while conv_req_o is high and conv_done_i has not been sampled. The next slot's channel appears in the cycle after conv_done_i is sampled high.
- R8: In the cycle after conv_done_i is sampled high during an active slot, res_valid_o pulses for one cycle. res_slot_o then gives the slot index (0 for the first slot) and res_chan_o gives the input that was converted.
- R9: seq_done_o pulses in the same cycle as the last slot's res_valid_o. In that cycle conv_req_o is 0, and it stays 0 until the next start.
- R10: A start pulse during an active sequence aborts it and restarts at slot 0 with the newly latched settings. If conv_done_i arrives in the same cycle as the start, the start wins and no result is produced. conv_done_i while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start pulse; latches all settings |
| sel_code_i | input | 4 | Channel select code (first or only input) |
| multi_i | input | 1 | 1 = step across inputs, 0 = single input |
| wrap_i | input | 4 | Highest input before returning to input 0 |
| len_i | input | 4 | Number of conversions in the sequence |
| conv_done_i | input | 1 | Conversion-done strobe from the converter |
| conv_req_o | output | 1 | Convert request, high while a slot is active |
| chan_o | output | 3 | Input number driven to the analog mux |
| res_valid_o | output | 1 | One-cycle pulse: a slot has completed |
| res_slot_o | output | 3 | Slot index of the completed conversion |
| res_chan_o | output | 3 | Input number of the completed conversion |
| seq_done_o | output | 1 | One-cycle pulse with the last result |

## Verification
A new start pulse and a conversion-done strobe can land on the same clock edge. The block must then discard the finishing slot and reload slot 0. The bench provokes this by watching its converter stub and raising start in exactly the cycle in which the stub raises done. It judges the outcome with a behavioural model checked on every clock, and with a directed check that only the restarted sequence's results appear. The same collision is also forced onto the last slot of a sequence. There the start must suppress both the final result and the completion pulse.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NUM_CH = 8;
    localparam int CODE_W = 4;
    localparam int LEN_W  = 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int SLOT_W = $clog2(NUM_CH);

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LEN_W-1:0]  len_t;

    localparam chan_t CH_TOP = chan_t'(NUM_CH - 1);

    typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

    typedef struct packed {
        logic  multi;
        chan_t wrap;
        slot_t last;
    } seq_cfg_t;

    typedef struct packed {
        slot_t slot;
        chan_t chan;
    } seq_res_t;

    // Codes beyond the last input all land on the top input.
    function automatic chan_t map_code(code_t c);
        if (int'(c) >= NUM_CH) return CH_TOP;
        return chan_t'(c);
    endfunction

    // Zero or out-of-range wrap settings act as the top input.
    function automatic chan_t eff_wrap(code_t w);
        if (w == '0 || int'(w) >= NUM_CH) return CH_TOP;
        return chan_t'(w);
    endfunction

    // Index of the final slot; zero or oversize length gives a full sequence.
    function automatic slot_t eff_last(len_t l);
        if (l == '0 || int'(l) > NUM_CH) return slot_t'(NUM_CH - 1);
        return slot_t'(l - 1'b1);
    endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  code_t    sel_code_i,
    input  logic     multi_i,
    input  code_t    wrap_i,
    input  len_t     len_i,
    output seq_cfg_t cfg_q,
    output chan_t    first_chan,
    output logic     first_high
);
    chan_t wrap_n;

    always_comb begin
        first_chan = map_code(sel_code_i);
        wrap_n     = eff_wrap(wrap_i);
        first_high = multi_i && (first_chan > wrap_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load_i) begin
            cfg_q.multi <= multi_i;
            cfg_q.wrap  <= wrap_n;
            cfg_q.last  <= eff_last(len_i);
        end
    end
endmodule

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
    import adc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  chan_t first_chan_i,
    input  logic  first_high_i,
    input  logic  step_i,
    input  logic  multi_i,
    input  chan_t wrap_i,
    output chan_t chan_q
);
    logic  top_wrap_q;
    chan_t chan_n;
    logic  top_wrap_n;

    always_comb begin
        chan_n     = chan_q;
        top_wrap_n = top_wrap_q;
        if (multi_i) begin
            if (top_wrap_q) begin
                if (chan_q == CH_TOP) begin
                    chan_n     = '0;
                    top_wrap_n = 1'b0;
                end else begin
                    chan_n = chan_q + 1'b1;
                end
            end else if (chan_q == wrap_i) begin
                chan_n = '0;
            end else begin
                chan_n = chan_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q     <= '0;
            top_wrap_q <= 1'b0;
        end else if (load_i) begin
            chan_q     <= first_chan_i;
            top_wrap_q <= first_high_i;
        end else if (step_i) begin
            chan_q     <= chan_n;
            top_wrap_q <= top_wrap_n;
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     done_i,
    input  slot_t    last_i,
    input  chan_t    chan_i,
    output logic     busy_o,
    output logic     step_o,
    output logic     res_valid_o,
    output seq_res_t res_o,
    output logic     seq_done_o
);
    seq_state_e state_q;
    slot_t      slot_q;
    logic       accept;
    logic       final_slot;

    always_comb begin
        busy_o     = (state_q == SEQ_RUN);
        accept     = busy_o && done_i && !start_i;
        final_slot = (slot_q == last_i);
        step_o     = accept && !final_slot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            slot_q      <= '0;
            res_valid_o <= 1'b0;
            res_o       <= '0;
            seq_done_o  <= 1'b0;
        end else begin
            res_valid_o <= accept;
            seq_done_o  <= accept && final_slot;
            if (accept) begin
                res_o.slot <= slot_q;
                res_o.chan <= chan_i;
            end
            if (start_i) begin
                state_q <= SEQ_RUN;
                slot_q  <= '0;
            end else if (accept) begin
                if (final_slot) begin
                    state_q <= SEQ_IDLE;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [3:0]  sel_code_i,
    input  logic        multi_i,
    input  logic [3:0]  wrap_i,
    input  logic [3:0]  len_i,
    input  logic        conv_done_i,
    output logic        conv_req_o,
    output logic [2:0]  chan_o,
    output logic        res_valid_o,
    output logic [2:0]  res_slot_o,
    output logic [2:0]  res_chan_o,
    output logic        seq_done_o
);
    seq_cfg_t cfg;
    chan_t    first_chan;
    logic     first_high;
    logic     step;
    chan_t    chan;
    seq_res_t res;

    adc_seq_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (start_i),
        .sel_code_i (sel_code_i),
        .multi_i    (multi_i),
        .wrap_i     (wrap_i),
        .len_i      (len_i),
        .cfg_q      (cfg),
        .first_chan (first_chan),
        .first_high (first_high)
    );

    adc_seq_chan u_chan (
        .clk          (clk),
        .rst          (rst),
        .load_i       (start_i),
        .first_chan_i (first_chan),
        .first_high_i (first_high),
        .step_i       (step),
        .multi_i      (cfg.multi),
        .wrap_i       (cfg.wrap),
        .chan_q       (chan)
    );

    adc_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .done_i      (conv_done_i),
        .last_i      (cfg.last),
        .chan_i      (chan),
        .busy_o      (conv_req_o),
        .step_o      (step),
        .res_valid_o (res_valid_o),
        .res_o       (res),
        .seq_done_o  (seq_done_o)
    );

    assign chan_o     = chan;
    assign res_slot_o = res.slot;
    assign res_chan_o = res.chan;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       conv_done_i,
    input logic       conv_req_o,
    input logic [2:0] chan_o,
    input logic       res_valid_o,
    input logic       seq_done_o,
    input logic       cfg_multi
);
    assert_chan_hold_R7: assert property (@(posedge clk) disable iff (rst)
        conv_req_o && !conv_done_i && !start_i |=> conv_req_o && $stable(chan_o));

    assert_result_cause_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> $past(conv_req_o && conv_done_i && !start_i));

    assert_done_with_last_R9: assert property (@(posedge clk) disable iff (rst)
        seq_done_o |-> res_valid_o && !conv_req_o);

    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> conv_req_o && !res_valid_o && !seq_done_o);

    assert_idle_ignores_done_R10: assert property (@(posedge clk) disable iff (rst)
        !conv_req_o |=> !res_valid_o);

    assert_single_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        conv_req_o && $past(conv_req_o) && !cfg_multi && !$past(start_i)
        |-> $stable(chan_o));
endmodule

bind adc_seq_ctrl adc_seq_checker u_adc_seq_checker (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .conv_done_i (conv_done_i),
    .conv_req_o  (conv_req_o),
    .chan_o      (chan_o),
    .res_valid_o (res_valid_o),
    .seq_done_o  (seq_done_o),
    .cfg_multi   (cfg.multi)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] code = '0;
    logic       multi = 1'b0;
    logic [3:0] wrap = '0;
    logic [3:0] len = '0;
    logic       stub_done = 1'b0;
    logic       extra_done = 1'b0;
    logic       conv_done;
    logic       conv_req;
    logic [2:0] chan;
    logic       res_valid;
    logic [2:0] res_slot;
    logic [2:0] res_chan;
    logic       seq_done;

    assign conv_done = stub_done | extra_done;

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk (clk), .rst (rst), .start_i (start), .sel_code_i (code),
        .multi_i (multi), .wrap_i (wrap), .len_i (len), .conv_done_i (conv_done),
        .conv_req_o (conv_req), .chan_o (chan), .res_valid_o (res_valid),
        .res_slot_o (res_slot), .res_chan_o (res_chan), .seq_done_o (seq_done)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // Behavioural reference model
    int m_busy, m_slot, m_chan, m_top, m_multi, m_wrap, m_len;
    int m_rv, m_rs, m_rc, m_done;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_slot = 0; m_chan = 0; m_top = 0; m_multi = 0;
            m_wrap = 7; m_len = 8; m_rv = 0; m_rs = 0; m_rc = 0; m_done = 0;
        end else if (start) begin
            m_busy  = 1;
            m_slot  = 0;
            m_chan  = (code > 7) ? 7 : int'(code);
            m_multi = multi;
            m_wrap  = (wrap == 0 || wrap > 7) ? 7 : int'(wrap);
            m_len   = (len == 0 || len > 8) ? 8 : int'(len);
            m_top   = (multi && m_chan > m_wrap) ? 1 : 0;
            m_rv = 0; m_done = 0;
        end else begin
            m_rv = 0; m_done = 0;
            if (m_busy != 0 && conv_done) begin
                m_rv = 1; m_rs = m_slot; m_rc = m_chan;
                if (m_slot == m_len - 1) begin
                    m_busy = 0; m_done = 1;
                end else begin
                    m_slot = m_slot + 1;
                    if (m_multi != 0) begin
                        if (m_top != 0) begin
                            if (m_chan == 7) begin m_chan = 0; m_top = 0; end
                            else m_chan = m_chan + 1;
                        end else if (m_chan == m_wrap) m_chan = 0;
                        else m_chan = m_chan + 1;
                    end
                end
            end
        end
    end

    task automatic fail(string tag, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    endtask

    task automatic check(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) fail(tag, what, act, exp);
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R7", "conv_req", int'(conv_req), (m_busy != 0) ? 1 : 0);
            if (m_busy != 0) check("R4", "chan", int'(chan), m_chan);
            check("R8", "res_valid", int'(res_valid), m_rv);
            if (m_rv != 0) begin
                check("R8", "res_slot", int'(res_slot), m_rs);
                check("R8", "res_chan", int'(res_chan), m_rc);
            end
            check("R9", "seq_done", int'(seq_done), m_done);
        end
    end

    // Converter stub: done strobe after a programmable latency
    int lat = 1;
    int scnt = 0;
    always @(negedge clk) begin
        if (rst) begin
            stub_done = 0; scnt = 0;
        end else if (stub_done) begin
            stub_done = 0; scnt = 0;
        end else if (conv_req) begin
            if (scnt >= lat) begin stub_done = 1; scnt = 0; end
            else scnt++;
        end else scnt = 0;
    end

    // Result collector
    int got_ch[$];
    int got_sl[$];
    int done_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin got_ch.push_back(int'(res_chan)); got_sl.push_back(int'(res_slot)); end
            if (seq_done) done_cnt++;
        end
    end

    int exp_ch[$];

    task automatic clear_log();
        got_ch.delete(); got_sl.delete(); done_cnt = 0;
    endtask

    task automatic pulse_start(logic [3:0] c, logic m, logic [3:0] w, logic [3:0] l);
        code = c; multi = m; wrap = w; len = l; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && done_cnt == 0; i++) begin
            @(negedge clk); #1;
        end
        repeat (3) begin @(negedge clk); #1; end
    endtask

    task automatic check_log(string tag);
        check(tag, "result count", got_ch.size(), exp_ch.size());
        check(tag, "done pulses", done_cnt, 1);
        for (int i = 0; i < exp_ch.size() && i < got_ch.size(); i++) begin
            check(tag, "channel", got_ch[i], exp_ch[i]);
            check(tag, "slot", got_sl[i], i);
        end
    endtask

    task automatic run_seq(string tag, logic [3:0] c, logic m, logic [3:0] w, logic [3:0] l);
        clear_log();
        pulse_start(c, m, w, l);
        wait_done();
        check_log(tag);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "conv_req in reset", int'(conv_req), 0);
        check("R1", "res_valid in reset", int'(res_valid), 0);
        check("R1", "seq_done in reset", int'(seq_done), 0);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R1", "conv_req after reset", int'(conv_req), 0);

        lat = 1;
        exp_ch = '{5, 5, 5};
        run_seq("R3", 4'd5, 1'b0, 4'd3, 4'd3);
        exp_ch = '{7, 7};
        run_seq("R2", 4'd12, 1'b0, 4'd0, 4'd2);
        lat = 0;
        exp_ch = '{2, 3, 4, 0, 1, 2};
        run_seq("R4", 4'd2, 1'b1, 4'd4, 4'd6);
        lat = 3;
        exp_ch = '{5, 6, 7, 0, 1};
        run_seq("R4", 4'd5, 1'b1, 4'd0, 4'd5);
        lat = 2;
        exp_ch = '{6, 7, 0, 1, 2, 0, 1};
        run_seq("R5", 4'd6, 1'b1, 4'd2, 4'd7);
        lat = 0;
        exp_ch = '{0, 1, 2, 3, 4, 5, 6, 7};
        run_seq("R6", 4'd0, 1'b1, 4'd7, 4'd0);
        exp_ch = '{1, 1, 1, 1, 1, 1, 1, 1};
        run_seq("R6", 4'd1, 1'b0, 4'd7, 4'd13);
        lat = 1;
        exp_ch = '{7, 0, 1};
        run_seq("R2", 4'd9, 1'b1, 4'd3, 4'd3);
        exp_ch = '{3, 4, 5, 6, 7, 0};
        run_seq("R4", 4'd3, 1'b1, 4'd11, 4'd6);

        // Restart mid-sequence with fresh settings
        lat = 2;
        clear_log();
        pulse_start(4'd0, 1'b1, 4'd7, 4'd8);
        for (int i = 0; i < 200 && got_ch.size() < 2; i++) begin @(negedge clk); #1; end
        clear_log();
        pulse_start(4'd4, 1'b0, 4'd0, 4'd2);
        wait_done();
        exp_ch = '{4, 4};
        check_log("R10");

        // Start lands on the same edge as conversion done
        lat = 1;
        clear_log();
        pulse_start(4'd1, 1'b1, 4'd7, 4'd4);
        for (int i = 0; i < 200 && !stub_done; i++) begin @(negedge clk); #1; end
        clear_log();
        pulse_start(4'd3, 1'b0, 4'd0, 4'd1);
        wait_done();
        exp_ch = '{3};
        check_log("R10");

        // Collision on the final slot suppresses the final result and done pulse
        lat = 1;
        clear_log();
        pulse_start(4'd2, 1'b0, 4'd0, 4'd1);
        for (int i = 0; i < 200 && !stub_done; i++) begin @(negedge clk); #1; end
        clear_log();
        pulse_start(4'd6, 1'b0, 4'd0, 4'd1);
        wait_done();
        exp_ch = '{6};
        check_log("R10");

        // Done strobe while idle
        extra_done = 1'b1;
        @(negedge clk); #1;
        extra_done = 1'b0;
        @(negedge clk); #1;
        check("R10", "res_valid after idle done", int'(res_valid), 0);
        check("R9", "conv_req idle", int'(conv_req), 0);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule